// File: doc/BRIEF.md
# Framebuffer Pixel Format Transfer Unit

This unit copies a rectangular image from one memory region to another and converts every pixel between packed colour encodings on the way. Each source pixel is fetched through a read port, decoded into four 8-bit channels (red, green, blue, alpha), re-encoded in the destination encoding and stored through a write port. One pulse on the start input launches a transfer, and the geometry and formats are captured at that moment. When the last destination pixel has been accepted, a one-cycle done interrupt is raised.

The read port uses a request channel and a response channel, each with valid/ready. The unit keeps at most one read in flight and never issues a read and a write in the same cycle. Back-pressure rules: once a request or a write is offered, its valid stays high and its address and data stay unchanged until ready is seen high at a clock edge. The unit accepts a read response only while it has a read outstanding (`rd_rsp_ready_o` high). Addresses are byte addresses. Read data is the 32-bit little-endian word that starts at the requested address. A write stores the low `wr_nbytes_o` bytes of `wr_data_o`, least significant byte at `wr_addr_o`.

An optional horizontal halving drops every second source pixel. The number of output pixels per row is then half the programmed destination width.

Top module: `pix_convert_copy`

## Requirements
- R1: Format codes are 0 = RGBA8 (4 bytes), 1 = RGB8 (3 bytes), 2 = RGB5A1 (2 bytes), 3 = RGBA4 (2 bytes). Sources accept codes 0, 2 and 3. Destinations accept codes 0 to 3. Any other code makes the transfer end with no memory access, `fmt_err_o` high and one done pulse. `fmt_err_o` is cleared by the next accepted start that has legal codes.
- R2: A 32-bit RGBA8 pixel holds alpha in bits 7:0, blue in 15:8, green in 23:16 and red in 31:24, for both reading and writing.
- R3: An RGB8 destination pixel is written as 3 bytes with blue in bits 7:0, green in 15:8 and red in 23:16.
- R4: An RGB5A1 pixel (the low 16 bits of its word) holds red in 15:11, green in 10:6, blue in 5:1 and alpha in bit 0. When written, each field takes the top bits of its 8-bit channel, so alpha is bit 7 of the alpha channel.
- R5: An RGBA4 pixel holds red in 15:12, green in 11:8, blue in 7:4 and alpha in 3:0. When written, each field takes the top 4 bits of its channel.
- R6: On decode, a 5-bit field v widens to (v<<3)|(v>>2), a 4-bit field to (v<<4)|v, and 1-bit alpha to 0x00 or 0xFF.
- R7: With halving set, each row has floor(dst_width/2) output pixels, and output pixel x reads source pixel 2x.
- R8: Output pixel (x,y) reads from src_base + (x*k + y*src_width)*source_bytes, where k is 2 when halving and 1 otherwise. It writes to dst_base + (x + y*row_pixels)*dest_bytes. Pixels are processed row by row, left to right.
- R9: `done_irq_o` is high for exactly one cycle, after the last write has been accepted. `busy_o` is high from the cycle after start until that pulse.
- R10: A pending read request or write keeps valid high and address and data stable until it is accepted. A read and a write are never offered in the same cycle.
- R11: A transfer with zero rows or zero output pixels per row makes no memory access, raises the done pulse and reports no error.
- R12: Start and configuration inputs are ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| src_base_i | input | AW | Source byte address |
| dst_base_i | input | AW | Destination byte address |
| src_width_i | input | DIM_W | Source row length in pixels |
| dst_width_i | input | DIM_W | Programmed destination width |
| rows_i | input | DIM_W | Number of rows |
| src_fmt_i | input | 3 | Source format code |
| dst_fmt_i | input | 3 | Destination format code |
| halve_i | input | 1 | Horizontal halving enable |
| busy_o | output | 1 | Transfer in progress |
| done_irq_o | output | 1 | One-cycle completion pulse |
| fmt_err_o | output | 1 | Last start had an illegal format code |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request ready |
| rd_req_addr_o | output | AW | Read byte address |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_ready_o | output | 1 | Read response ready |
| rd_rsp_data_i | input | 32 | Read response word |
| wr_valid_o | output | 1 | Write valid |
| wr_ready_i | input | 1 | Write ready |
| wr_addr_o | output | AW | Write byte address |
| wr_data_o | output | 32 | Write data, low bytes used |
| wr_nbytes_o | output | 3 | Number of bytes written (2, 3 or 4) |

## Verification
Some properties are checked by assertions on every cycle. These are the handshake rules under back-pressure (stable valid, address and data, and never a read and a write together), the single-cycle done pulse, the fact that an error only appears together with that pulse, that `busy_o` holds until completion, and that write sizes are legal. The bit and byte layouts, channel widening and truncation, halving, the address sequence and the order of transfers can only be shown by the bench. Its behavioural model predicts every read address and every write, and compares them at each handshake while the memory side varies ready and response latency. Format aborts, empty transfers and starts issued while busy are also covered only by bench scenarios.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

  localparam logic [2:0] FMT_RGBA8  = 3'd0;
  localparam logic [2:0] FMT_RGB8   = 3'd1;
  localparam logic [2:0] FMT_RGB5A1 = 3'd2;
  localparam logic [2:0] FMT_RGBA4  = 3'd3;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
    logic [7:0] a;
  } rgba_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_WRITE,
    ST_DONE
  } xfer_st_e;

  function automatic logic src_fmt_ok(input logic [2:0] f);
    return (f == FMT_RGBA8) || (f == FMT_RGB5A1) || (f == FMT_RGBA4);
  endfunction

  function automatic logic dst_fmt_ok(input logic [2:0] f);
    return (f <= FMT_RGBA4);
  endfunction

  function automatic logic [2:0] fmt_bytes(input logic [2:0] f);
    case (f)
      FMT_RGBA8: return 3'd4;
      FMT_RGB8:  return 3'd3;
      default:   return 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/ptx_decode.sv
module ptx_decode
  import ptx_pkg::*;
(
  input  logic [2:0]  fmt_i,
  input  logic [31:0] word_i,
  output rgba_t       px_o
);
  // widened colour channels, index 0 red, 1 green, 2 blue
  logic [7:0] wide5 [3];
  logic [7:0] wide4 [3];

  for (genvar c = 0; c < 3; c++) begin : g_chan
    localparam int P5 = 11 - 5 * c;
    localparam int P4 = 12 - 4 * c;
    assign wide5[c] = {word_i[P5+4:P5], word_i[P5+4:P5+2]};
    assign wide4[c] = {word_i[P4+3:P4], word_i[P4+3:P4]};
  end

  always_comb begin
    case (fmt_i)
      FMT_RGB5A1: px_o = '{r: wide5[0], g: wide5[1], b: wide5[2],
                           a: {8{word_i[0]}}};
      FMT_RGBA4:  px_o = '{r: wide4[0], g: wide4[1], b: wide4[2],
                           a: {word_i[3:0], word_i[3:0]}};
      default:    px_o = '{r: word_i[31:24], g: word_i[23:16],
                           b: word_i[15:8], a: word_i[7:0]};
    endcase
  end
endmodule

// File: rtl/ptx_encode.sv
module ptx_encode
  import ptx_pkg::*;
(
  input  logic [2:0]  fmt_i,
  input  rgba_t       px_i,
  output logic [31:0] word_o
);
  always_comb begin
    case (fmt_i)
      FMT_RGB8:   word_o = {8'h00, px_i.r, px_i.g, px_i.b};
      FMT_RGB5A1: word_o = {16'h0000, px_i.r[7:3], px_i.g[7:3],
                            px_i.b[7:3], px_i.a[7]};
      FMT_RGBA4:  word_o = {16'h0000, px_i.r[7:4], px_i.g[7:4],
                            px_i.b[7:4], px_i.a[7:4]};
      default:    word_o = {px_i.r, px_i.g, px_i.b, px_i.a};
    endcase
  end
endmodule

// File: rtl/ptx_walker.sv
module ptx_walker #(
  parameter int AW    = 32,
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             step_i,
  input  logic [AW-1:0]    src_base_i,
  input  logic [AW-1:0]    dst_base_i,
  input  logic [DIM_W-1:0] src_width_i,
  input  logic [DIM_W-1:0] row_px_i,
  input  logic [DIM_W-1:0] rows_i,
  input  logic [2:0]       src_bytes_i,
  input  logic [2:0]       dst_bytes_i,
  input  logic             halve_i,
  output logic [AW-1:0]    src_addr_o,
  output logic [AW-1:0]    dst_addr_o,
  output logic             last_o
);
  localparam int PAD = AW - DIM_W;

  logic [DIM_W-1:0] x_q, y_q, row_px_q, rows_q;
  logic [AW-1:0]    row_start_q, row_step_q, px_step_q;
  logic [2:0]       dst_step_q;
  logic             row_end;

  assign row_end = (x_q == row_px_q - 1'b1);
  assign last_o  = row_end && (y_q == rows_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q         <= '0;
      y_q         <= '0;
      row_px_q    <= '0;
      rows_q      <= '0;
      row_start_q <= '0;
      row_step_q  <= '0;
      px_step_q   <= '0;
      dst_step_q  <= '0;
      src_addr_o  <= '0;
      dst_addr_o  <= '0;
    end else if (init_i) begin
      x_q         <= '0;
      y_q         <= '0;
      row_px_q    <= row_px_i;
      rows_q      <= rows_i;
      row_start_q <= src_base_i;
      src_addr_o  <= src_base_i;
      dst_addr_o  <= dst_base_i;
      dst_step_q  <= dst_bytes_i;
      row_step_q  <= {{PAD{1'b0}}, src_width_i} << ((src_bytes_i == 3'd4) ? 2 : 1);
      px_step_q   <= AW'(src_bytes_i) << halve_i;
    end else if (step_i) begin
      dst_addr_o <= dst_addr_o + AW'(dst_step_q);
      if (row_end) begin
        x_q         <= '0;
        y_q         <= y_q + 1'b1;
        row_start_q <= row_start_q + row_step_q;
        src_addr_o  <= row_start_q + row_step_q;
      end else begin
        x_q        <= x_q + 1'b1;
        src_addr_o <= src_addr_o + px_step_q;
      end
    end
  end
endmodule

// File: rtl/ptx_ctrl.sv
module ptx_ctrl
  import ptx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     cfg_ok_i,
  input  logic     empty_i,
  input  logic     rd_req_ready_i,
  input  logic     rd_rsp_valid_i,
  input  logic     wr_ready_i,
  input  logic     last_i,
  output xfer_st_e state_o,
  output logic     accept_o,
  output logic     capture_o,
  output logic     step_o
);
  xfer_st_e nxt;

  assign accept_o  = (state_o == ST_IDLE) && start_i;
  assign capture_o = (state_o == ST_WAIT) && rd_rsp_valid_i;
  assign step_o    = (state_o == ST_WRITE) && wr_ready_i;

  always_comb begin
    nxt = state_o;
    case (state_o)
      ST_IDLE:  if (start_i) nxt = (!cfg_ok_i || empty_i) ? ST_DONE : ST_REQ;
      ST_REQ:   if (rd_req_ready_i) nxt = ST_WAIT;
      ST_WAIT:  if (rd_rsp_valid_i) nxt = ST_WRITE;
      ST_WRITE: if (wr_ready_i) nxt = last_i ? ST_DONE : ST_REQ;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_o <= ST_IDLE;
    else        state_o <= nxt;
  end
endmodule

// File: rtl/pix_convert_copy.sv
module pix_convert_copy
  import ptx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [AW-1:0]    src_base_i,
  input  logic [AW-1:0]    dst_base_i,
  input  logic [DIM_W-1:0] src_width_i,
  input  logic [DIM_W-1:0] dst_width_i,
  input  logic [DIM_W-1:0] rows_i,
  input  logic [2:0]       src_fmt_i,
  input  logic [2:0]       dst_fmt_i,
  input  logic             halve_i,
  output logic             busy_o,
  output logic             done_irq_o,
  output logic             fmt_err_o,
  output logic             rd_req_valid_o,
  input  logic             rd_req_ready_i,
  output logic [AW-1:0]    rd_req_addr_o,
  input  logic             rd_rsp_valid_i,
  output logic             rd_rsp_ready_o,
  input  logic [31:0]      rd_rsp_data_i,
  output logic             wr_valid_o,
  input  logic             wr_ready_i,
  output logic [AW-1:0]    wr_addr_o,
  output logic [31:0]      wr_data_o,
  output logic [2:0]       wr_nbytes_o
);
  xfer_st_e         state;
  logic             accept, capture, step, last, cfg_ok, empty;
  logic [DIM_W-1:0] row_px;
  logic [2:0]       sfmt_q, dfmt_q;
  rgba_t            px;
  logic [31:0]      enc_word;

  assign row_px = halve_i ? (dst_width_i >> 1) : dst_width_i;
  assign cfg_ok = src_fmt_ok(src_fmt_i) && dst_fmt_ok(dst_fmt_i);
  assign empty  = (row_px == '0) || (rows_i == '0);

  ptx_ctrl u_ctrl (
    .clk, .rst_n,
    .start_i        (start_i),
    .cfg_ok_i       (cfg_ok),
    .empty_i        (empty),
    .rd_req_ready_i (rd_req_ready_i),
    .rd_rsp_valid_i (rd_rsp_valid_i),
    .wr_ready_i     (wr_ready_i),
    .last_i         (last),
    .state_o        (state),
    .accept_o       (accept),
    .capture_o      (capture),
    .step_o         (step)
  );

  ptx_walker #(.AW(AW), .DIM_W(DIM_W)) u_walk (
    .clk, .rst_n,
    .init_i      (accept),
    .step_i      (step),
    .src_base_i  (src_base_i),
    .dst_base_i  (dst_base_i),
    .src_width_i (src_width_i),
    .row_px_i    (row_px),
    .rows_i      (rows_i),
    .src_bytes_i (fmt_bytes(src_fmt_i)),
    .dst_bytes_i (fmt_bytes(dst_fmt_i)),
    .halve_i     (halve_i),
    .src_addr_o  (rd_req_addr_o),
    .dst_addr_o  (wr_addr_o),
    .last_o      (last)
  );

  ptx_decode u_dec (.fmt_i(sfmt_q), .word_i(rd_rsp_data_i), .px_o(px));
  ptx_encode u_enc (.fmt_i(dfmt_q), .px_i(px), .word_o(enc_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sfmt_q      <= FMT_RGBA8;
      dfmt_q      <= FMT_RGBA8;
      fmt_err_o   <= 1'b0;
      wr_data_o   <= '0;
      wr_nbytes_o <= 3'd4;
    end else begin
      if (accept) begin
        sfmt_q      <= src_fmt_i;
        dfmt_q      <= dst_fmt_i;
        fmt_err_o   <= !cfg_ok;
        wr_nbytes_o <= fmt_bytes(dst_fmt_i);
      end
      if (capture) wr_data_o <= enc_word;
    end
  end

  assign busy_o         = (state != ST_IDLE);
  assign done_irq_o     = (state == ST_DONE);
  assign rd_req_valid_o = (state == ST_REQ);
  assign rd_rsp_ready_o = (state == ST_WAIT);
  assign wr_valid_o     = (state == ST_WRITE);
endmodule

// File: rtl/ptx_checker.sv
module ptx_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          done_irq_o,
  input logic          fmt_err_o,
  input logic          rd_req_valid_o,
  input logic          rd_req_ready_i,
  input logic [AW-1:0] rd_req_addr_o,
  input logic          wr_valid_o,
  input logic          wr_ready_i,
  input logic [AW-1:0] wr_addr_o,
  input logic [31:0]   wr_data_o,
  input logic [2:0]    wr_nbytes_o
);
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_req_addr_o));

  a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o)
      && $stable(wr_data_o) && $stable(wr_nbytes_o));

  a_r10_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid_o && wr_valid_o));

  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq_o |=> !done_irq_o && !busy_o);

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_irq_o |=> busy_o);

  a_r1_err_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fmt_err_o) |-> done_irq_o);

  a_r1_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err_o |-> !rd_req_valid_o && !wr_valid_o);

  a_r3_nbytes_legal: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (wr_nbytes_o >= 3'd2) && (wr_nbytes_o <= 3'd4));
endmodule

bind pix_convert_copy ptx_checker #(.AW(AW)) u_chk (
  .clk, .rst_n, .busy_o, .done_irq_o, .fmt_err_o,
  .rd_req_valid_o, .rd_req_ready_i, .rd_req_addr_o,
  .wr_valid_o, .wr_ready_i, .wr_addr_o, .wr_data_o, .wr_nbytes_o
);

// File: tb/sim_pix_convert_copy.sv
`timescale 1ns/1ps
module sim_pix_convert_copy;
  localparam int AW = 32;
  localparam int DW = 12;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic          start = 0, halve = 0;
  logic [AW-1:0] sbase = 0, dbase = 0;
  logic [DW-1:0] sw = 0, dwid = 0, rows = 0;
  logic [2:0]    sfmt = 0, dfmt = 0;
  logic          busy, irq, err;
  logic          rqv, rqr = 0, rsv = 0, rsr, wv, wr = 0;
  logic [AW-1:0] rqa, wa;
  logic [31:0]   rsd = 0, wd;
  logic [2:0]    wn;

  pix_convert_copy #(.AW(AW), .DIM_W(DW)) u0 (
    .clk, .rst_n, .start_i(start), .src_base_i(sbase), .dst_base_i(dbase),
    .src_width_i(sw), .dst_width_i(dwid), .rows_i(rows), .src_fmt_i(sfmt),
    .dst_fmt_i(dfmt), .halve_i(halve), .busy_o(busy), .done_irq_o(irq),
    .fmt_err_o(err), .rd_req_valid_o(rqv), .rd_req_ready_i(rqr),
    .rd_req_addr_o(rqa), .rd_rsp_valid_i(rsv), .rd_rsp_ready_o(rsr),
    .rd_rsp_data_i(rsd), .wr_valid_o(wv), .wr_ready_i(wr), .wr_addr_o(wa),
    .wr_data_o(wd), .wr_nbytes_o(wn));

  int checks = 0, errors = 0, cyc = 0, irq_cnt = 0;
  logic [7:0] mem [0:4095];
  logic [31:0] rdq[$], wdq[$], waq[$];
  int wnq[$];
  string tag = "R2";

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int rd8(input int a); return int'(mem[a & 4095]); endfunction

  // behavioural pixel model: decode to channels, then encode
  task automatic model_px(input int sa, input int sf, input int df,
                          output int data, output int nb);
    int r, g, b, a, v;
    v = rd8(sa) + rd8(sa + 1) * 256;
    case (sf)
      0: begin a = rd8(sa); b = rd8(sa+1); g = rd8(sa+2); r = rd8(sa+3); end
      2: begin
        r = (v / 2048) % 32; g = (v / 64) % 32; b = (v / 2) % 32;
        r = r * 8 + r / 4; g = g * 8 + g / 4; b = b * 8 + b / 4;
        a = (v % 2) * 255;
      end
      default: begin
        r = ((v / 4096) % 16) * 17; g = ((v / 256) % 16) * 17;
        b = ((v / 16) % 16) * 17;   a = (v % 16) * 17;
      end
    endcase
    case (df)
      0: begin data = a + b * 256 + g * 65536 + r * 16777216; nb = 4; end
      1: begin data = b + g * 256 + r * 65536; nb = 3; end
      2: begin data = (r/8)*2048 + (g/8)*64 + (b/8)*2 + a/128; nb = 2; end
      default: begin data = (r/16)*4096 + (g/16)*256 + (b/16)*16 + a/16; nb = 2; end
    endcase
  endtask

  // memory side and per-clock comparison against the model queues
  bit pend = 0, rsp_hs = 0, wr_stall = 0, rd_stall = 0;
  int lat = 0;
  logic [31:0] pdata, hold_wd, hold_wa, hold_ra;
  logic [2:0] hold_wn;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rsp_hs) rsv = 0;
      if (pend) begin
        if (lat == 0) begin rsv = 1; rsd = pdata; pend = 0; end
        else lat--;
      end
      rqr = (cyc % 4) != 1;
      wr  = (cyc % 5) != 2 && (cyc % 5) != 3;
      #1;
      if (rd_stall) chk(rqv && rqa == hold_ra, "R10", "read request held", rqa, hold_ra);
      if (wr_stall) chk(wv && wd == hold_wd && wa == hold_wa && wn == hold_wn,
                        "R10", "write held", wd, hold_wd);
      rd_stall = rqv && !rqr; hold_ra = rqa;
      wr_stall = wv && !wr;   hold_wd = wd; hold_wa = wa; hold_wn = wn;
      if (rqv && rqr) begin
        if (rdq.size() == 0) chk(0, "R11", "unexpected read", rqa, 0);
        else chk(rqa == rdq.pop_front(), "R8", "read address", rqa, rqa);
        pend = 1; lat = cyc % 3;
        pdata = {mem[(rqa+3)&4095], mem[(rqa+2)&4095], mem[(rqa+1)&4095], mem[rqa&4095]};
      end
      rsp_hs = rsv && rsr;
      if (wv && wr) begin
        if (waq.size() == 0) chk(0, "R11", "unexpected write", wa, 0);
        else begin
          logic [31:0] ea, ed; int en;
          ea = waq.pop_front(); ed = wdq.pop_front(); en = wnq.pop_front();
          chk(wa == ea, "R8", "write address", wa, ea);
          chk(wd == ed, tag, "write data", wd, ed);
          chk(int'(wn) == en, tag, "write byte count", wn, en);
        end
      end
      if (irq) begin
        irq_cnt++;
        chk(waq.size() == 0 && rdq.size() == 0, "R9", "irq before last write",
            waq.size(), 0);
      end
    end
  end

  task automatic run(input int ib, input int ob, input int iw, input int ow,
                     input int h, input int sf, input int df, input bit sc,
                     input bit exp_err, input bit poke, input string t);
    int ew, k, sb, db, base;
    tag = t;
    ew = sc ? ow / 2 : ow; k = sc ? 2 : 1;
    sb = (sf == 0) ? 4 : 2; db = (df == 0) ? 4 : (df == 1) ? 3 : 2;
    if (!exp_err)
      for (int y = 0; y < h; y++)
        for (int x = 0; x < ew; x++) begin
          int sa, d, n;
          sa = ib + (x * k + y * iw) * sb;
          model_px(sa, sf, df, d, n);
          rdq.push_back(sa); waq.push_back(ob + (x + y * ew) * db);
          wdq.push_back(d); wnq.push_back(n);
        end
    base = irq_cnt;
    @(negedge clk);
    sbase = ib; dbase = ob; sw = iw; dwid = ow; rows = h;
    sfmt = sf; dfmt = df; halve = sc; start = 1;
    @(negedge clk); start = 0;
    if (poke) begin
      repeat (6) @(negedge clk);
      chk(busy == 1, "R12", "busy mid-transfer", busy, 1);
      sbase = 'h300; dbase = 'h900; sw = 2; dwid = 2; rows = 1;
      sfmt = 2; dfmt = 3; halve = 0; start = 1;
      @(negedge clk); start = 0;
    end
    while (irq_cnt == base) @(negedge clk);
    #2;
    chk(err == exp_err, "R1", "format error status", err, exp_err);
    chk(rdq.size() == 0 && waq.size() == 0, t, "all pixels transferred",
        waq.size(), 0);
    repeat (4) @(negedge clk);
    chk(busy == 0 && irq_cnt == base + 1, "R9", "single done pulse, idle after",
        irq_cnt - base, 1);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !irq && !err && !rqv && !wv, "R9", "reset state",
        {busy, irq, err, rqv, wv}, 0);
    rst_n = 1;
    run('h100, 'h800, 4, 3, 2, 0, 0, 0, 0, 0, "R2");
    run('h100, 'h800, 8, 6, 2, 2, 1, 1, 0, 0, "R3");
    run('h140, 'h840, 3, 3, 3, 3, 2, 0, 0, 0, "R4");
    run('h180, 'h880, 5, 5, 1, 0, 3, 1, 0, 0, "R5");
    run('h1c0, 'h8c0, 4, 4, 2, 2, 0, 0, 0, 0, "R6");
    run('h100, 'h800, 2, 2, 1, 1, 0, 0, 1, 0, "R1");
    run('h100, 'h800, 2, 2, 1, 0, 6, 0, 1, 0, "R1");
    run('h200, 'h900, 6, 6, 1, 3, 0, 1, 0, 0, "R7");
    run('h100, 'h800, 4, 4, 0, 0, 0, 0, 0, 0, "R11");
    run('h100, 'h800, 4, 1, 2, 0, 0, 1, 0, 0, "R11");
    run('h240, 'h940, 5, 5, 2, 0, 1, 0, 0, 1, "R12");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule